// File: doc/BRIEF.md
# Command Packet Stream Decoder

This block sits behind a command fetcher. It takes one 32-bit command word per valid/ready handshake and turns the stream into events for downstream logic. Each header word names one of four packet kinds in its top two bits. Register bursts and register pairs become register-write events, each carrying a dword register index and a data word. Opcode packets become a dispatch event followed by one event per payload word. Filler words are swallowed.

The decoder counts the payload words still owed to the current packet and goes back to expecting a header after the last one. An opcode that is not in the parameterised supported list sets a sticky error flag. Its payload is then skipped silently, so the stream stays aligned. The block has no buffer: an input word is accepted only in the cycle its event is taken, or, for words that produce no event, immediately.

Top module: `cmd_stream_decoder`

## Requirements
- R1: Header bits [31:30] select the packet kind: 2'b00 register burst, 2'b01 register pair, 2'b10 filler, 2'b11 opcode packet.
- R2: A burst header with count field [29:16] = n produces no event itself and is followed by n+1 register-write events (out_kind 0), the first one to the index in header bits [10:0], each carrying its payload word on out_data.
- R3: With header bit 15 clear, the register index of a burst rises by one per payload word and wraps from 0x7FF to 0x000.
- R4: With header bit 15 set, every payload word of a burst is written to the starting index.
- R5: A pair header produces no event; its next two words become register writes, first to index [10:0], then to index [21:11].
- R6: A filler header (kind 2'b10) is accepted at once and produces no event.
- R7: A supported opcode header produces a dispatch event (out_kind 1) with out_opcode = bits [15:8], out_count = bits [29:16] and out_data = the header. It is followed by n+1 payload events (out_kind 2), each carrying the opcode and the number of payload words still to come after it. Register-write events carry zero opcode and zero count, and opcode events carry a zero register index.
- R8: An opcode header whose opcode is not in the supported list (default 0x23, 0x26, 0x29, 0x32, 0x94, 0x9A, 0x9B) sets err_flag, which then stays set. The header and its n+1 payload words produce no event.
- R9: While out_valid is high and out_ready is low, in_ready is low. No event is dropped, duplicated or reordered.
- R10: A synchronous reset returns the decoder to expecting a header with the payload counter cleared and err_flag low. A packet cut off by reset is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word taken this cycle |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Event offered |
| out_ready | input | 1 | Event taken this cycle |
| out_kind | output | 2 | 0 register write, 1 opcode dispatch, 2 opcode payload |
| out_reg | output | REG_W (11) | Register dword index |
| out_data | output | 32 | Data word, or the header word for a dispatch |
| out_opcode | output | OP_W (8) | Opcode of dispatch/payload events |
| out_count | output | CNT_W (14) | Count field on dispatch, words still to come on payload |
| err_flag | output | 1 | Sticky unsupported-opcode flag |

## Verification
Directed packets cover the following cases:
- A burst starting at 0x7FE, which shows wrap versus saturation.
- A repeat-mode burst, which separates bit-15 handling from plain increment.
- A single-word burst, which exposes off-by-one counting of the n+1 rule.
- A pair with distinct indices, which separates the order of the two targets.
- Fillers, and an unsupported opcode followed by a supported one, which shows whether skipped payload keeps the stream in step.

A long run of randomly mixed packets with random output stalls and input gaps checks that back-pressure neither loses nor repeats events. A reset issued in the middle of a burst shows whether the leftover count leaks into the next packet.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
   localparam int WORD_W  = 32;
   localparam int TYPE_LO = 30;
   localparam int CNT_LO  = 16;
   localparam int RPT_BIT = 15;
   localparam int OP_LO   = 8;
   localparam int REGA_LO = 0;
   localparam int REGB_LO = 11;

   typedef enum logic [1:0] {
      PK_BURST = 2'b00,
      PK_PAIR  = 2'b01,
      PK_FILL  = 2'b10,
      PK_OPC   = 2'b11
   } pkt_kind_e;

   typedef enum logic [1:0] {
      EV_REG    = 2'd0,
      EV_OPHDR  = 2'd1,
      EV_OPDATA = 2'd2
   } ev_kind_e;

   typedef enum logic [2:0] {
      M_HDR, M_BURST, M_PAIR, M_OPC, M_SKIP
   } dec_mode_e;
endpackage

// File: rtl/cmd_hdr_fields.sv
module cmd_hdr_fields
   import cmd_dec_pkg::*;
#(
   parameter int REG_W = 11,
   parameter int CNT_W = 14,
   parameter int OP_W  = 8
) (
   input  logic [WORD_W-1:0] word,
   output pkt_kind_e         kind,
   output logic [CNT_W-1:0]  cnt,
   output logic [REG_W-1:0]  reg_a,
   output logic [REG_W-1:0]  reg_b,
   output logic              rpt,
   output logic [OP_W-1:0]   opcode
);
   if (CNT_LO + CNT_W > TYPE_LO) begin : g_bad_cnt
      $error("count field overlaps the type bits");
   end
   if (REGB_LO + REG_W > CNT_LO + 6) begin : g_bad_reg
      $error("second register field too wide");
   end
   if (OP_LO + OP_W > CNT_LO) begin : g_bad_op
      $error("opcode field overlaps the count field");
   end

   assign kind   = pkt_kind_e'(word[TYPE_LO +: 2]);
   assign cnt    = word[CNT_LO +: CNT_W];
   assign reg_a  = word[REGA_LO +: REG_W];
   assign reg_b  = word[REGB_LO +: REG_W];
   assign rpt    = word[RPT_BIT];
   assign opcode = word[OP_LO +: OP_W];
endmodule

// File: rtl/cmd_op_match.sv
module cmd_op_match #(
   parameter int                      OP_W    = 8,
   parameter int                      NUM_OPS = 7,
   parameter logic [NUM_OPS*OP_W-1:0] OP_LIST = '0
) (
   input  logic [OP_W-1:0] opcode,
   output logic            hit
);
   if (NUM_OPS < 1) begin : g_bad_num
      $error("supported opcode list is empty");
   end

   logic [NUM_OPS-1:0] match;

   for (genvar g = 0; g < NUM_OPS; g++) begin : g_cmp
      assign match[g] = (opcode == OP_LIST[g*OP_W +: OP_W]);
   end

   assign hit = |match;
endmodule

// File: rtl/cmd_payload_seq.sv
module cmd_payload_seq
   import cmd_dec_pkg::*;
#(
   parameter int REG_W = 11,
   parameter int CNT_W = 14,
   parameter int OP_W  = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hdr_take,
   input  logic             pay_take,
   input  pkt_kind_e        kind,
   input  logic [CNT_W-1:0] cnt,
   input  logic [REG_W-1:0] reg_a,
   input  logic [REG_W-1:0] reg_b,
   input  logic             rpt,
   input  logic [OP_W-1:0]  opcode,
   input  logic             op_hit,
   output dec_mode_e        mode,
   output logic [CNT_W-1:0] rem,
   output logic [REG_W-1:0] idx,
   output logic [OP_W-1:0]  op_q,
   output logic             err
);
   logic [REG_W-1:0] idx2;
   logic             rpt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode  <= M_HDR;
         rem   <= '0;
         idx   <= '0;
         idx2  <= '0;
         rpt_q <= 1'b0;
         op_q  <= '0;
         err   <= 1'b0;
      end else if (hdr_take) begin
         unique case (kind)
            PK_BURST: begin
               mode  <= M_BURST;
               rem   <= cnt;
               idx   <= reg_a;
               rpt_q <= rpt;
            end
            PK_PAIR: begin
               mode  <= M_PAIR;
               rem   <= CNT_W'(1);
               idx   <= reg_a;
               idx2  <= reg_b;
               rpt_q <= 1'b0;
            end
            PK_FILL: begin
               rem <= '0;
            end
            PK_OPC: begin
               rem  <= cnt;
               op_q <= opcode;
               if (op_hit) begin
                  mode <= M_OPC;
               end else begin
                  mode <= M_SKIP;
                  err  <= 1'b1;
               end
            end
            default: ;
         endcase
      end else if (pay_take) begin
         if (rem == '0) mode <= M_HDR;
         else           rem  <= rem - CNT_W'(1);
         if (mode == M_PAIR)  idx <= idx2;
         else if (!rpt_q)     idx <= idx + REG_W'(1);
      end
   end
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
   import cmd_dec_pkg::*;
#(
   parameter int                      REG_W   = 11,
   parameter int                      CNT_W   = 14,
   parameter int                      OP_W    = 8,
   parameter int                      NUM_OPS = 7,
   parameter logic [NUM_OPS*OP_W-1:0] OP_LIST =
      {8'h9B, 8'h9A, 8'h94, 8'h32, 8'h29, 8'h26, 8'h23}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [31:0]       in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [REG_W-1:0]  out_reg,
   output logic [31:0]       out_data,
   output logic [OP_W-1:0]   out_opcode,
   output logic [CNT_W-1:0]  out_count,
   output logic              err_flag
);
   pkt_kind_e        hf_kind;
   logic [CNT_W-1:0] hf_cnt;
   logic [REG_W-1:0] hf_ra, hf_rb;
   logic             hf_rpt;
   logic [OP_W-1:0]  hf_op;
   logic             op_hit;
   dec_mode_e        mode;
   logic [CNT_W-1:0] rem;
   logic [REG_W-1:0] idx;
   logic [OP_W-1:0]  op_q;
   logic             expect_hdr, rem_is_zero, emits, accept;

   cmd_hdr_fields #(.REG_W(REG_W), .CNT_W(CNT_W), .OP_W(OP_W)) u_fields (
      .word(in_word), .kind(hf_kind), .cnt(hf_cnt), .reg_a(hf_ra),
      .reg_b(hf_rb), .rpt(hf_rpt), .opcode(hf_op)
   );

   cmd_op_match #(.OP_W(OP_W), .NUM_OPS(NUM_OPS), .OP_LIST(OP_LIST)) u_match (
      .opcode(hf_op), .hit(op_hit)
   );

   cmd_payload_seq #(.REG_W(REG_W), .CNT_W(CNT_W), .OP_W(OP_W)) u_seq (
      .clk(clk), .rst(rst),
      .hdr_take(accept && expect_hdr), .pay_take(accept && !expect_hdr),
      .kind(hf_kind), .cnt(hf_cnt), .reg_a(hf_ra), .reg_b(hf_rb),
      .rpt(hf_rpt), .opcode(hf_op), .op_hit(op_hit),
      .mode(mode), .rem(rem), .idx(idx), .op_q(op_q), .err(err_flag)
   );

   assign expect_hdr  = (mode == M_HDR);
   assign rem_is_zero = (rem == '0);
   assign emits       = expect_hdr ? (hf_kind == PK_OPC && op_hit)
                                   : (mode != M_SKIP);
   assign out_valid   = in_valid && emits;
   assign in_ready    = emits ? out_ready : 1'b1;
   assign accept      = in_valid && in_ready;
   assign out_data    = in_word;

   always_comb begin
      out_kind   = EV_REG;
      out_reg    = '0;
      out_opcode = '0;
      out_count  = '0;
      if (expect_hdr) begin
         out_kind   = EV_OPHDR;
         out_opcode = hf_op;
         out_count  = hf_cnt;
      end else if (mode == M_BURST || mode == M_PAIR) begin
         out_kind = EV_REG;
         out_reg  = idx;
      end else begin
         out_kind   = EV_OPDATA;
         out_opcode = op_q;
         out_count  = rem;
      end
   end
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk (
   input logic        clk,
   input logic        rst,
   input logic        in_valid,
   input logic        in_ready,
   input logic [31:0] in_word,
   input logic        out_valid,
   input logic        out_ready,
   input logic        err_flag,
   input logic        expect_hdr,
   input logic        rem_is_zero
);
   // R9: a stalled event blocks the input
   a_r9_stall_blocks: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);

   // R6: filler accepted at once, no event
   a_r6_filler_silent: assert property (@(posedge clk) disable iff (rst)
      expect_hdr && in_valid && in_word[31:30] == 2'b10 |-> !out_valid && in_ready);

   // R2: burst and pair headers produce no event
   a_r2_hdr_silent: assert property (@(posedge clk) disable iff (rst)
      expect_hdr && in_valid && !in_word[31] |-> !out_valid);

   // R8: error flag is sticky
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
      err_flag |=> err_flag);

   // R10: reset returns to header state with cleared counter and flag
   a_r10_reset_state: assert property (@(posedge clk)
      rst |=> expect_hdr && rem_is_zero && !err_flag);
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
   .err_flag(err_flag), .expect_hdr(expect_hdr), .rem_is_zero(rem_is_zero)
);

// File: tb/cmd_stream_decoder_tb.sv
module cmd_stream_decoder_tb;
   logic        clk = 1'b0;
   logic        rst, in_valid, out_ready;
   logic [31:0] in_word;
   logic        in_ready, out_valid, err_flag;
   logic [1:0]  out_kind;
   logic [10:0] out_reg;
   logic [31:0] out_data;
   logic [7:0]  out_opcode;
   logic [13:0] out_count;

   typedef struct packed {
      logic [1:0]  k;
      logic [10:0] r;
      logic [31:0] d;
      logic [7:0]  op;
      logic [13:0] c;
   } ev_t;

   ev_t exp_q[$];
   int  checks = 0, fails = 0, ready_pct = 100;
   bit  err_exp = 1'b0, done = 1'b0;

   always #5 clk = ~clk;

   cmd_stream_decoder u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
      .out_kind(out_kind), .out_reg(out_reg), .out_data(out_data),
      .out_opcode(out_opcode), .out_count(out_count), .err_flag(err_flag)
   );

   function automatic bit supported(input logic [7:0] op);
      return op inside {8'h23, 8'h26, 8'h29, 8'h32, 8'h94, 8'h9A, 8'h9B};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [67:0] act, input logic [67:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // event monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (!rst && out_valid && out_ready) begin
         ev_t a;
         a = '{out_kind, out_reg, out_data, out_opcode, out_count};
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected event", 68'(a), 68'(0));
         end else begin
            ev_t e;
            string tag;
            e = exp_q.pop_front();
            tag = (e.k == 2'd0) ? "R2 R3 R4 R5 register write" :
                  (e.k == 2'd1) ? "R7 dispatch" : "R7 payload";
            chk(a == e, "R9", tag, 68'(a), 68'(e));
         end
      end
   end

   // random output stalls
   initial begin
      out_ready = 1'b1;
      forever begin
         @(posedge clk);
         #1 out_ready = (($urandom % 100) < ready_pct);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic send(input logic [31:0] w);
      in_valid = 1'b1;
      in_word  = w;
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1 in_valid = 1'b0;
      if (ready_pct < 100 && ($urandom % 4) == 0) begin
         repeat ($urandom % 3) @(posedge clk);
         #1;
      end
   endtask

   task automatic burst(input logic [10:0] start, input int n, input bit rpt);
      logic [10:0] idx = start;
      send({2'b00, 14'(n), rpt, 4'b0, start});
      for (int i = 0; i <= n; i++) begin
         logic [31:0] d = $urandom;
         exp_q.push_back('{2'd0, idx, d, 8'h0, 14'h0});
         send(d);
         if (!rpt) idx = idx + 11'd1;
      end
   endtask

   task automatic pair(input logic [10:0] a, input logic [10:0] b);
      logic [31:0] d0 = $urandom, d1 = $urandom;
      send({2'b01, 8'h0, b, a});
      exp_q.push_back('{2'd0, a, d0, 8'h0, 14'h0});
      send(d0);
      exp_q.push_back('{2'd0, b, d1, 8'h0, 14'h0});
      send(d1);
   endtask

   task automatic opc(input logic [7:0] op, input int n);
      logic [31:0] h = {2'b11, 14'(n), op, 8'h00};
      bit ok = supported(op);
      if (ok) exp_q.push_back('{2'd1, 11'h0, h, op, 14'(n)});
      else    err_exp = 1'b1;
      send(h);
      for (int i = 0; i <= n; i++) begin
         logic [31:0] d = $urandom;
         if (ok) exp_q.push_back('{2'd2, 11'h0, d, op, 14'(n - i)});
         send(d);
      end
   endtask

   task automatic drain(input string req);
      repeat (6) @(posedge clk);
      #1;
      chk(exp_q.size() == 0, req, "events outstanding", 68'(exp_q.size()), 68'(0));
   endtask

   initial begin
      void'($urandom(32'd4711));
      rst = 1'b1; in_valid = 1'b0; in_word = '0;
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      chk(!out_valid && in_ready, "R10", "ready after reset", 68'({out_valid, in_ready}), 68'(2'b01));
      chk(!err_flag, "R10", "err after reset", 68'(err_flag), 68'(0));
      rst = 1'b0;

      burst(11'h7FE, 2, 1'b0);              // R3 wrap
      burst(11'h123, 3, 1'b1);              // R4 repeat
      burst(11'h010, 0, 1'b0);              // R2 single word
      pair(11'h005, 11'h7FA);               // R5 order
      drain("R2");
      send(32'h8000_0000);                  // R6 filler
      send(32'h8000_0000);
      drain("R6");
      chk(!err_flag, "R6", "filler leaves err clear", 68'(err_flag), 68'(0));
      opc(8'h26, 0);                        // R7
      opc(8'h9B, 3);
      drain("R7");
      opc(8'h55, 2);                        // R8 unsupported, skipped
      opc(8'h29, 1);                        // R1 back in sync
      drain("R8");
      chk(err_flag == 1'b1, "R8", "err set", 68'(err_flag), 68'(1));

      // random mix with stalls (R9)
      for (int p = 0; p < 80; p++) begin
         ready_pct = 20 + ($urandom % 81);
         case ($urandom % 4)
            0: burst(11'($urandom), $urandom % 5, 1'($urandom));
            1: pair(11'($urandom), 11'($urandom));
            2: send(32'h8000_0000);
            default: begin
               logic [7:0] op;
               op = (($urandom % 6) == 0) ? 8'h77 :
                    (($urandom % 2) == 0) ? 8'h9A : 8'h23;
               opc(op, $urandom % 5);
            end
         endcase
      end
      ready_pct = 100;
      drain("R9");
      chk(err_flag == err_exp, "R8", "sticky err after mix", 68'(err_flag), 68'(err_exp));

      // R10 reset in the middle of a burst
      begin
         logic [31:0] d = $urandom;
         send({2'b00, 14'd3, 1'b0, 4'b0, 11'h040});
         exp_q.push_back('{2'd0, 11'h040, d, 8'h0, 14'h0});
         send(d);
      end
      drain("R10");
      rst = 1'b1;
      @(posedge clk);
      #1 rst = 1'b0;
      err_exp = 1'b0;
      chk(!err_flag, "R10", "err cleared by reset", 68'(err_flag), 68'(0));
      pair(11'h001, 11'h002);
      drain("R10");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule